// File: doc/BRIEF.md
# Prioritized Interrupt Selector

This block picks which pending interrupt, if any, a hart should take in the current cycle. Its inputs are the pending vector, the current privilege level, the machine and supervisor global enables, the delegation mask and the debug-cause field. Delegated interrupts target supervisor level. All other interrupts target machine level.

The block first forms the machine-targeted set. It uses the supervisor-targeted set only when the machine set is empty. In the surviving set it applies a fixed group order and then picks the lowest set bit inside the winning group. The decision is registered. A take strobe and an interrupt-flagged cause appear one cycle after the inputs that produced them. Trap entry, status updates and pipeline control belong to the surrounding core.

Top module: `irq_select`

## Requirements
- R1: While synchronous reset (`rst_n` low) is sampled, `take_o` goes to 0 and `cause_o` goes to all zeros.
- R2: Privilege is encoded as user=0, supervisor=1, machine=3. Machine-targeted interrupts (pending and not delegated) are eligible when the privilege is not machine. At machine privilege they are eligible only when `m_gie_i` is 1.
- R3: Supervisor-targeted interrupts (pending and delegated) are eligible at user privilege, and at supervisor privilege when `s_gie_i` is 1. They are never eligible at privilege 2 or 3.
- R4: If any eligible machine-targeted bit exists, all supervisor-targeted bits are ignored, whatever their group.
- R5: When `dbg_cause_i` is nonzero, no interrupt is taken.
- R6: Group order, from highest to lowest: any bit at index 11 or above, then bit 9, then bits 1 and 3, then bits 5 and 7. If no eligible bit falls in any of these groups, the whole eligible set competes.
- R7: Inside the winning group the lowest index wins. `cause_o` holds that index in its low bits, has bit XLEN-1 set and is zero elsewhere. When nothing is taken, `cause_o` is zero.
- R8: `take_o` and `cause_o` change one clock after the inputs they reflect. They are re-evaluated every cycle, so `take_o` drops in the cycle after the pending bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pend_i | input | XLEN | Pending interrupt bits |
| deleg_i | input | XLEN | Delegation mask; 1 sends the interrupt to supervisor level |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| dbg_cause_i | input | 3 | Debug cause; nonzero means the hart is in debug mode |
| take_o | output | 1 | Registered strobe: take an interrupt |
| cause_o | output | XLEN | Registered cause with the interrupt flag in bit XLEN-1 |

## Verification
Target-level masking and group priority can act on the same cycle. This happens when a delegated interrupt from a higher group, such as supervisor external, is pending together with an undelegated interrupt from a lower group, such as machine timer. The bench drives that mix at user and supervisor privilege and expects the machine timer index. A bench that honoured group order across both targets would instead report index 9. A randomized phase then mixes the two sets, the enables and the debug field, and checks every cycle against a behavioural model.

// File: rtl/irq_select.sv
module irq_select #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] pend_i,
  input  logic [XLEN-1:0] deleg_i,
  input  logic [1:0]      priv_i,
  input  logic            m_gie_i,
  input  logic            s_gie_i,
  input  logic [2:0]      dbg_cause_i,
  output logic            take_o,
  output logic [XLEN-1:0] cause_o
);
  localparam int IW = $clog2(XLEN);
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;
  localparam logic [XLEN-1:0] ONE = XLEN'(1);
  localparam logic [XLEN-1:0] HI_MASK  = {XLEN{1'b1}} << 11;
  localparam logic [XLEN-1:0] EXT_MASK = ONE << 9;
  localparam logic [XLEN-1:0] SW_MASK  = (ONE << 1) | (ONE << 3);
  localparam logic [XLEN-1:0] TM_MASK  = (ONE << 5) | (ONE << 7);

  wire m_en = (priv_i != PRV_M) || m_gie_i;
  wire s_en = (priv_i == PRV_U) || ((priv_i == PRV_S) && s_gie_i);

  wire [XLEN-1:0] m_set = m_en ? (pend_i & ~deleg_i) : '0;
  wire [XLEN-1:0] s_set = s_en ? (pend_i & deleg_i) : '0;
  wire [XLEN-1:0] win   = (|m_set) ? m_set : s_set;

  logic [XLEN-1:0] grp;
  always_comb begin
    if      (|(win & HI_MASK))  grp = win & HI_MASK;
    else if (|(win & EXT_MASK)) grp = win & EXT_MASK;
    else if (|(win & SW_MASK))  grp = win & SW_MASK;
    else if (|(win & TM_MASK))  grp = win & TM_MASK;
    else                        grp = win;
  end

  function automatic logic [IW-1:0] lowest(input logic [XLEN-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = XLEN - 1; i >= 0; i--)
      if (v[i]) r = IW'(i);
    return r;
  endfunction

  wire hit = (dbg_cause_i == 3'd0) && (|win);
  wire [XLEN-1:0] nxt_cause = {1'b1, {(XLEN-1-IW){1'b0}}, lowest(grp)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_o  <= 1'b0;
      cause_o <= '0;
    end else begin
      take_o  <= hit;
      cause_o <= hit ? nxt_cause : '0;
    end
  end
endmodule

// File: rtl/irq_select_chk.sv
module irq_select_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] pend_i,
  input logic [1:0]      priv_i,
  input logic            m_gie_i,
  input logic [2:0]      dbg_cause_i,
  input logic            take_o,
  input logic [XLEN-1:0] cause_o
);
  localparam int IW = $clog2(XLEN);

  p_dbg_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dbg_cause_i) != 3'd0) |-> !take_o);

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> cause_o[XLEN-1]);

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (cause_o == '0));

  p_was_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ((($past(pend_i) >> cause_o[IW-1:0]) & XLEN'(1)) != '0));

  p_mlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past((priv_i == 2'd3) && !m_gie_i) |-> !take_o);
endmodule

bind irq_select irq_select_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .priv_i(priv_i),
  .m_gie_i(m_gie_i), .dbg_cause_i(dbg_cause_i),
  .take_o(take_o), .cause_o(cause_o)
);

// File: tb/irq_select_tb_top.sv
`timescale 1ns/1ps
module irq_select_tb_top;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [XLEN-1:0] pend = '0;
  logic [XLEN-1:0] deleg = '0;
  logic [1:0]      priv = 2'd0;
  logic            mie = 1'b0;
  logic            sie = 1'b0;
  logic [2:0]      dbg = 3'd0;
  logic            take;
  logic [XLEN-1:0] cause;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_select #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .deleg_i(deleg), .priv_i(priv),
    .m_gie_i(mie), .s_gie_i(sie), .dbg_cause_i(dbg),
    .take_o(take), .cause_o(cause)
  );

  function automatic bit in_group(int i, int g);
    case (g)
      0: return i >= 11;
      1: return i == 9;
      2: return (i == 1) || (i == 3);
      3: return (i == 5) || (i == 7);
      default: return 1'b1;
    endcase
  endfunction

  function automatic void model(output bit et, output logic [XLEN-1:0] ec);
    logic [XLEN-1:0] cand;
    bit menab, senab;
    int pick;
    menab = (priv != 2'd3) || mie;
    senab = (priv == 2'd0) || ((priv == 2'd1) && sie);
    cand = menab ? (pend & ~deleg) : '0;
    if (cand == '0) cand = senab ? (pend & deleg) : '0;
    if (dbg != 3'd0) cand = '0;
    pick = -1;
    for (int g = 0; g < 5 && pick < 0; g++)
      for (int i = 0; i < XLEN && pick < 0; i++)
        if (cand[i] && in_group(i, g)) pick = i;
    et = (pick >= 0);
    ec = et ? ((XLEN'(1) << (XLEN-1)) | XLEN'(pick)) : '0;
  endfunction

  task automatic step(input string tag, input logic [XLEN-1:0] p, input logic [XLEN-1:0] d,
                      input logic [1:0] pv, input bit m, input bit s, input logic [2:0] db);
    bit et;
    logic [XLEN-1:0] ec;
    @(negedge clk);
    pend = p; deleg = d; priv = pv; mie = m; sie = s; dbg = db;
    model(et, ec);
    @(posedge clk);
    #1;
    checks++;
    if (take !== et || cause !== ec) begin
      errors++;
      $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h", tag, take, cause, et, ec);
    end
  endtask

  function automatic logic [XLEN-1:0] b(int i);
    return XLEN'(1) << i;
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pend = b(7); priv = 2'd0;
    repeat (2) @(posedge clk);
    #1;
    checks++;
    if (take !== 1'b0 || cause !== '0) begin
      errors++;
      $display("FAIL R1: take=%0b cause=%h expected take=0 cause=0", take, cause);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2 machine enable
    step("R2", b(7), '0, 2'd3, 1, 0, 0);
    step("R2", b(7), '0, 2'd3, 0, 1, 0);
    step("R2", b(7), '0, 2'd1, 0, 0, 0);
    step("R2", b(7), '0, 2'd2, 0, 0, 0);
    // R3 supervisor enable
    step("R3", b(5), b(5), 2'd1, 1, 0, 0);
    step("R3", b(5), b(5), 2'd1, 0, 1, 0);
    step("R3", b(5), b(5), 2'd0, 0, 0, 0);
    step("R3", b(5), b(5), 2'd3, 1, 1, 0);
    step("R3", b(5), b(5), 2'd2, 1, 1, 0);
    // R4 machine set masks supervisor set
    step("R4", b(9) | b(7), b(9), 2'd0, 0, 0, 0);
    step("R4", b(3) | b(1), b(1), 2'd1, 0, 1, 0);
    step("R4", b(11) | b(5), b(11), 2'd1, 0, 1, 0);
    // R5 debug mode
    step("R5", b(11), '0, 2'd0, 0, 0, 3'd1);
    step("R5", b(11), '0, 2'd0, 0, 0, 3'd0);
    step("R5", b(3), '0, 2'd0, 0, 0, 3'd4);
    // R6 group order
    step("R6", b(7) | b(3) | b(9), '0, 2'd0, 0, 0, 0);
    step("R6", b(7) | b(3), '0, 2'd0, 0, 0, 0);
    step("R6", b(7) | b(5), '0, 2'd0, 0, 0, 0);
    step("R6", b(20) | b(9), '0, 2'd0, 0, 0, 0);
    step("R6", b(11) | b(40), '0, 2'd0, 0, 0, 0);
    step("R6", b(63) | b(1), '0, 2'd0, 0, 0, 0);
    step("R6", b(0) | b(2) | b(7), '0, 2'd0, 0, 0, 0);
    step("R6", b(4) | b(10), '0, 2'd0, 0, 0, 0);
    // R7 lowest in group, idle cause
    step("R7", '0, '0, 2'd0, 1, 1, 0);
    step("R7", b(1) | b(3), '0, 2'd0, 0, 0, 0);
    step("R7", b(0) | b(2), '0, 2'd0, 0, 0, 0);
    step("R7", b(12) | b(13) | b(50), '0, 2'd3, 1, 0, 0);
    // R8 per-cycle re-evaluation
    step("R8", b(5), '0, 2'd0, 0, 0, 0);
    step("R8", '0, '0, 2'd0, 0, 0, 0);
    step("R8", b(9), b(9), 2'd0, 0, 0, 0);

    for (int n = 0; n < 3000; n++) begin
      logic [XLEN-1:0] rp, rd;
      rp = {$urandom, $urandom} & {$urandom, $urandom} & {32'h0, $urandom};
      if ($urandom_range(0, 7) == 0) rp = rp | b($urandom_range(0, XLEN-1));
      if ($urandom_range(0, 3) == 0) rp = rp & 64'hAAA;
      rd = {$urandom, $urandom};
      step("mixed", rp, rd, 2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 5) == 0) ? 3'($urandom_range(1, 7)) : 3'd0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule